// File: doc/BRIEF.md
# Cascadable Paired FIR Filter

Two identical direct-form FIR lanes of 64 taps each share one clock. In the default arrangement every lane filters its own sample stream and drives its own result port. The pair can also be joined into a single 128-tap filter. In that arrangement the primary lane (lane 0) passes the sample that falls off the end of its delay line into the delay line of the secondary lane (lane 1). The secondary's partial tap sum is then added to the primary's, and the total leaves on the primary result port.

Each lane has a sample input with a valid strobe and a coefficient write port. It also has a two-bit mode field and an enable bit. Mode and enable are captured only on a synchronous clear, which also empties both delay lines, so an arrangement change never mixes old and new samples. Coefficients and samples are signed 16-bit, with coefficients in Q1.15. Accumulation is wide enough for a full 128-tap sum. Each result is rounded half-up and saturated back to 16 bits.

Top module: `pfir_pair`

## Requirements
- R1: With both mode fields at 2'b00, each lane outputs round_sat(sum over k=0..63 of h[k]*x[n-k]) over its own accepted samples. x[n] is the newest sample and h[k] is the coefficient written at address k. Cycles without a valid strobe do not shift the delay line.
- R2: A sample accepted at rising edge E gives its result on the output port at the second rising edge after E. The output valid is high for exactly that one cycle.
- R3: round_sat(a) = floor((a + 2^14) / 2^15), clipped to the range -32768..32767.
- R4: With the captured primary mode at 2'b10 and the captured secondary mode at 2'b01, the primary result is round_sat of the sum over k=0..127 of g[k]*x[n-k]. Here g[k] is the primary's coefficient k for k<64, and the secondary's coefficient k-64 for k>=64.
- R5: While the secondary's captured mode bit 0 is set, its delay line is fed only from the primary's discarded oldest sample, when the primary accepts a sample with mode bit 1 set. Its own sample input and valid strobe have no effect.
- R6: A lane whose captured enable is 0 never asserts its output valid. A secondary with its enable at 0 still supplies its partial sum to a joined primary.
- R7: Mode and enable inputs are captured only in a cycle with clr high. Changes at any other time have no effect.
- R8: clr zeroes both delay lines and cancels every result still in the pipeline. A sample presented together with clr is dropped. Coefficients are kept.
- R9: After reset both output valids are low, both captured modes are 2'b00 and both enables are 0, so no result appears until a clear enables a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear; captures mode and enable |
| cfg_mode_p | input | 2 | Primary mode field (bit 1: hand oldest sample onward) |
| cfg_en_p | input | 1 | Primary output enable |
| cfg_mode_s | input | 2 | Secondary mode field (bit 0: take input from primary) |
| cfg_en_s | input | 1 | Secondary output enable |
| p_din | input | 16 | Primary sample |
| p_din_vld | input | 1 | Primary sample strobe |
| s_din | input | 16 | Secondary sample |
| s_din_vld | input | 1 | Secondary sample strobe |
| p_cw_en | input | 1 | Primary coefficient write strobe |
| p_cw_addr | input | 6 | Primary coefficient index |
| p_cw_data | input | 16 | Primary coefficient value |
| s_cw_en | input | 1 | Secondary coefficient write strobe |
| s_cw_addr | input | 6 | Secondary coefficient index |
| s_cw_data | input | 16 | Secondary coefficient value |
| p_dout | output | 16 | Primary result |
| p_dout_vld | output | 1 | Primary result valid |
| s_dout | output | 16 | Secondary result |
| s_dout_vld | output | 1 | Secondary result valid |

## Verification
The first pattern is independent random streams with irregular valid gaps on both lanes. It separates per-lane delay-line shifting from cross-lane leakage and shows whether idle cycles are skipped. The joined pattern keeps driving random data into the secondary input while the primary streams. Only a correct 128-tap hand-over and a correct partial-sum addition match the reference, and any use of the secondary's own input is exposed. Single-tap coefficients with half-LSB samples tell half-up rounding apart from truncation or rounding away from zero, and full-scale coefficients with full-scale runs reach both saturation limits. A clear in mid-stream, and mode pins moved without a clear, show whether in-flight results are flushed and whether the mode is captured only at the clear.

// File: rtl/pfir_pkg.sv
package pfir_pkg;
   typedef enum logic [1:0] {
      PM_SOLO = 2'b00,
      PM_TAKE = 2'b01,
      PM_GIVE = 2'b10,
      PM_BOTH = 2'b11
   } pfir_mode_e;

   // guard bits needed to sum 'terms' products without overflow
   function automatic int guard_bits(input int terms);
      return $clog2(terms);
   endfunction
endpackage

// File: rtl/pfir_coef_bank.sv
module pfir_coef_bank #(
   parameter int CW   = 16,
   parameter int TAPS = 64,
   localparam int AW  = $clog2(TAPS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [CW-1:0]             wr_data,
   output logic [TAPS-1:0][CW-1:0]   coefs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coefs <= '0;
      end else if (wr_en) begin
         coefs[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/pfir_lane.sv
module pfir_lane #(
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int TAPS = 64,
   parameter int ACW  = 39,
   localparam int AW  = $clog2(TAPS),
   localparam int PW  = DW + CW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic [DW-1:0]         din,
   input  logic                  din_vld,
   input  logic [DW-1:0]         casc_in,
   input  logic                  casc_vld,
   input  logic                  use_casc,
   input  logic                  cw_en,
   input  logic [AW-1:0]         cw_addr,
   input  logic [CW-1:0]         cw_data,
   output logic [DW-1:0]         tail,
   output logic signed [ACW-1:0] psum,
   output logic                  psum_vld
);
   logic [TAPS-1:0][CW-1:0] coefs;
   logic [TAPS-1:0][DW-1:0] dline;
   logic signed [PW-1:0]    prod [TAPS];
   logic signed [ACW-1:0]   mac;
   logic [DW-1:0]           sample;
   logic                    shifted;
   logic                    pend;

   pfir_coef_bank #(.CW(CW), .TAPS(TAPS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cw_en),
      .wr_addr (cw_addr),
      .wr_data (cw_data),
      .coefs   (coefs)
   );

   assign sample  = use_casc ? casc_in : din;
   assign shifted = !clr && (use_casc ? casc_vld : din_vld);
   assign tail    = dline[TAPS-1];

   always_comb begin
      for (int k = 0; k < TAPS; k++) begin
         prod[k] = $signed(dline[k]) * $signed(coefs[k]);
      end
   end

   always_comb begin
      mac = '0;
      for (int k = 0; k < TAPS; k++) begin
         mac = mac + ACW'(prod[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dline    <= '0;
         pend     <= 1'b0;
         psum_vld <= 1'b0;
         psum     <= '0;
      end else begin
         if (clr) begin
            dline <= '0;
         end else if (shifted) begin
            dline <= {dline[TAPS-2:0], sample};
         end
         pend     <= shifted;
         psum_vld <= pend && !clr;
         if (pend) begin
            psum <= mac;
         end
      end
   end

   // a partial sum is always the image of a shift two edges earlier
   assert_psum_age_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      psum_vld |-> $past(shifted, 2));

   // clear empties the delay line
   assert_clr_empties_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tail == '0));
endmodule

// File: rtl/pfir_round.sv
module pfir_round #(
   parameter int DW   = 16,
   parameter int ACW  = 39,
   parameter int FRAC = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic signed [ACW-1:0] acc,
   input  logic                  acc_vld,
   output logic signed [DW-1:0]  dout,
   output logic                  dout_vld
);
   localparam logic signed [ACW:0] HALF = (ACW+1)'(1) <<< (FRAC - 1);
   localparam logic signed [ACW:0] MAXV = (ACW+1)'((64'sd1 <<< (DW - 1)) - 1);
   localparam logic signed [ACW:0] MINV = ~MAXV;

   logic signed [ACW:0] biased;
   logic signed [ACW:0] scaled;
   logic signed [DW-1:0] clipped;

   assign biased = $signed({acc[ACW-1], acc}) + HALF;
   assign scaled = biased >>> FRAC;

   always_comb begin
      if (scaled > MAXV) begin
         clipped = MAXV[DW-1:0];
      end else if (scaled < MINV) begin
         clipped = MINV[DW-1:0];
      end else begin
         clipped = scaled[DW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
      end else begin
         dout_vld <= acc_vld && !clr;
         if (acc_vld) begin
            dout <= clipped;
         end
      end
   end

   assert_vld_origin_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> $past(acc_vld));
endmodule

// File: rtl/pfir_pair.sv
module pfir_pair
   import pfir_pkg::*;
#(
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int TAPS = 64,
   parameter int FRAC = 15,
   localparam int AW  = $clog2(TAPS),
   localparam int ACW = DW + CW + guard_bits(2 * TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [1:0]           cfg_mode_p,
   input  logic                 cfg_en_p,
   input  logic [1:0]           cfg_mode_s,
   input  logic                 cfg_en_s,
   input  logic [DW-1:0]        p_din,
   input  logic                 p_din_vld,
   input  logic [DW-1:0]        s_din,
   input  logic                 s_din_vld,
   input  logic                 p_cw_en,
   input  logic [AW-1:0]        p_cw_addr,
   input  logic [CW-1:0]        p_cw_data,
   input  logic                 s_cw_en,
   input  logic [AW-1:0]        s_cw_addr,
   input  logic [CW-1:0]        s_cw_data,
   output logic signed [DW-1:0] p_dout,
   output logic                 p_dout_vld,
   output logic signed [DW-1:0] s_dout,
   output logic                 s_dout_vld
);
   if (TAPS < 2 || (1 << AW) != TAPS) begin : g_chk_taps
      $error("pfir_pair: TAPS must be a power of two of at least 2");
   end
   if (FRAC < 1 || FRAC > ACW - DW) begin : g_chk_frac
      $error("pfir_pair: FRAC out of range");
   end

   pfir_mode_e mode_q [2];
   logic [1:0] en_q;
   logic       joined;

   logic [DW-1:0]         ln_din  [2];
   logic                  ln_dvld [2];
   logic [DW-1:0]         ln_tail [2];
   logic                  ln_cvld [2];
   logic                  ln_use  [2];
   logic                  ln_cwe  [2];
   logic [AW-1:0]         ln_cwa  [2];
   logic [CW-1:0]         ln_cwd  [2];
   logic signed [ACW-1:0] ln_psum [2];
   logic                  ln_pvld [2];
   logic signed [ACW-1:0] rd_acc  [2];
   logic                  rd_avld [2];
   logic signed [DW-1:0]  rd_out  [2];
   logic                  rd_ovld [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q[0] <= PM_SOLO;
         mode_q[1] <= PM_SOLO;
         en_q      <= '0;
      end else if (clr) begin
         mode_q[0] <= pfir_mode_e'(cfg_mode_p);
         mode_q[1] <= pfir_mode_e'(cfg_mode_s);
         en_q      <= {cfg_en_s, cfg_en_p};
      end
   end

   assign joined = (mode_q[0] == PM_GIVE) && (mode_q[1] == PM_TAKE);

   assign ln_din[0] = p_din;     assign ln_din[1] = s_din;
   assign ln_dvld[0] = p_din_vld; assign ln_dvld[1] = s_din_vld;
   assign ln_cwe[0] = p_cw_en;   assign ln_cwe[1] = s_cw_en;
   assign ln_cwa[0] = p_cw_addr; assign ln_cwa[1] = s_cw_addr;
   assign ln_cwd[0] = p_cw_data; assign ln_cwd[1] = s_cw_data;

   // only lane 0 may hand its oldest sample on; only lane 1 may take it
   assign ln_cvld[0] = 1'b0;
   assign ln_use[0]  = 1'b0;
   assign ln_cvld[1] = !clr && p_din_vld && mode_q[0][1];
   assign ln_use[1]  = mode_q[1][0];

   assign rd_acc[0] = joined ? (ln_psum[0] + ln_psum[1]) : ln_psum[0];
   assign rd_acc[1] = ln_psum[1];

   for (genvar i = 0; i < 2; i++) begin : g_lane
      pfir_lane #(.DW(DW), .CW(CW), .TAPS(TAPS), .ACW(ACW)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .din      (ln_din[i]),
         .din_vld  (ln_dvld[i]),
         .casc_in  (ln_tail[1-i]),
         .casc_vld (ln_cvld[i]),
         .use_casc (ln_use[i]),
         .cw_en    (ln_cwe[i]),
         .cw_addr  (ln_cwa[i]),
         .cw_data  (ln_cwd[i]),
         .tail     (ln_tail[i]),
         .psum     (ln_psum[i]),
         .psum_vld (ln_pvld[i])
      );

      assign rd_avld[i] = ln_pvld[i] && en_q[i];

      pfir_round #(.DW(DW), .ACW(ACW), .FRAC(FRAC)) u_round (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .acc      (rd_acc[i]),
         .acc_vld  (rd_avld[i]),
         .dout     (rd_out[i]),
         .dout_vld (rd_ovld[i])
      );
   end

   assign p_dout     = rd_out[0];
   assign p_dout_vld = rd_ovld[0];
   assign s_dout     = rd_out[1];
   assign s_dout_vld = rd_ovld[1];

   assert_mode_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ($stable(mode_q[0]) && $stable(mode_q[1]) && $stable(en_q)));

   assert_sec_silent_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[1] |-> !s_dout_vld);

   assert_sec_ignores_input_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1][0] && !clr && !(p_din_vld && mode_q[0][1])) |=> $stable(ln_tail[1]));

   assert_clr_flush_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!p_dout_vld && !s_dout_vld));
endmodule

// File: tb/tb_pfir_pair.sv
module tb_pfir_pair;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic [1:0] cfg_mode_p = 2'b00, cfg_mode_s = 2'b00;
   logic cfg_en_p = 1'b0, cfg_en_s = 1'b0;
   logic [15:0] p_din = '0, s_din = '0;
   logic p_din_vld = 1'b0, s_din_vld = 1'b0;
   logic p_cw_en = 1'b0, s_cw_en = 1'b0;
   logic [5:0] p_cw_addr = '0, s_cw_addr = '0;
   logic [15:0] p_cw_data = '0, s_cw_data = '0;
   logic signed [15:0] p_dout, s_dout;
   logic p_dout_vld, s_dout_vld;

   always #4 clk = ~clk;

   pfir_pair dut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .cfg_mode_p(cfg_mode_p), .cfg_en_p(cfg_en_p),
      .cfg_mode_s(cfg_mode_s), .cfg_en_s(cfg_en_s),
      .p_din(p_din), .p_din_vld(p_din_vld),
      .s_din(s_din), .s_din_vld(s_din_vld),
      .p_cw_en(p_cw_en), .p_cw_addr(p_cw_addr), .p_cw_data(p_cw_data),
      .s_cw_en(s_cw_en), .s_cw_addr(s_cw_addr), .s_cw_data(s_cw_data),
      .p_dout(p_dout), .p_dout_vld(p_dout_vld),
      .s_dout(s_dout), .s_dout_vld(s_dout_vld)
   );

   typedef struct {
      bit    pv;
      int    pd;
      bit    sv;
      int    sd;
      string tag;
   } exp_t;

   exp_t  pipe[$];
   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;
   string tag = "R9";

   int hp[64], hs[64], cp[64], cs[64];
   int mp = 0, ms = 0, ep = 0, es = 0;

   function automatic int rsat(input longint a);
      longint q;
      q = (a + 64'sd16384) >>> 15;
      if (q > 32767) return 32767;
      if (q < -32768) return -32768;
      return int'(q);
   endfunction

   function automatic longint dot(input int h[64], input int c[64]);
      longint s = 0;
      for (int k = 0; k < 64; k++) s += longint'(h[k]) * longint'(c[k]);
      return s;
   endfunction

   function automatic int rnd16();
      return int'($urandom_range(0, 65535)) - 32768;
   endfunction

   task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
      end
   endtask

   // one clock: compare the result due now, then drive this cycle and model it
   task automatic step(input bit c, input bit vp, input int xp, input bit vs, input int xs,
                       input bit wp, input int wpd, input bit ws, input int wsd, input int wa);
      exp_t e;
      bit sshift;
      int tl;
      @(negedge clk);
      if (pipe.size() == 3) begin
         e = pipe.pop_front();
         chk(p_dout_vld == e.pv, e.tag, "p_dout_vld", int'(p_dout_vld), int'(e.pv));
         chk(s_dout_vld == e.sv, e.tag, "s_dout_vld", int'(s_dout_vld), int'(e.sv));
         if (e.pv) chk(int'(p_dout) == e.pd, e.tag, "p_dout", int'(p_dout), e.pd);
         if (e.sv) chk(int'(s_dout) == e.sd, e.tag, "s_dout", int'(s_dout), e.sd);
      end
      clr = c; p_din_vld = vp; p_din = 16'(xp); s_din_vld = vs; s_din = 16'(xs);
      p_cw_en = wp; s_cw_en = ws; p_cw_addr = 6'(wa); s_cw_addr = 6'(wa);
      p_cw_data = 16'(wpd); s_cw_data = 16'(wsd);
      if (wp) cp[wa] = wpd;
      if (ws) cs[wa] = wsd;
      e.tag = tag;
      if (c) begin
         foreach (pipe[i]) begin pipe[i].pv = 0; pipe[i].sv = 0; end
         mp = int'(cfg_mode_p); ms = int'(cfg_mode_s); ep = int'(cfg_en_p); es = int'(cfg_en_s);
         for (int k = 0; k < 64; k++) begin hp[k] = 0; hs[k] = 0; end
         e.pv = 0; e.sv = 0; e.pd = 0; e.sd = 0;
      end else begin
         sshift = ms[0] ? (vp && mp[1]) : vs;
         tl = hp[63];
         if (vp) begin
            for (int k = 63; k > 0; k--) hp[k] = hp[k-1];
            hp[0] = xp;
         end
         if (sshift) begin
            for (int k = 63; k > 0; k--) hs[k] = hs[k-1];
            hs[0] = ms[0] ? tl : xs;
         end
         e.pv = vp && (ep != 0);
         e.sv = sshift && (es != 0);
         e.pd = rsat(dot(hp, cp) + ((mp == 2 && ms == 1) ? dot(hs, cs) : 64'sd0));
         e.sd = rsat(dot(hs, cs));
      end
      pipe.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      for (int k = 0; k < 64; k++) begin hp[k] = 0; hs[k] = 0; cp[k] = 0; cs[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      chk(p_dout_vld == 0, "R9", "p_dout_vld after reset", int'(p_dout_vld), 0);
      chk(s_dout_vld == 0, "R9", "s_dout_vld after reset", int'(s_dout_vld), 0);
      chk(p_dout == 0, "R9", "p_dout after reset", int'(p_dout), 0);
      tag = "R9";
      for (int i = 0; i < 10; i++) step(0, 1, rnd16(), 1, rnd16(), 0, 0, 0, 0, 0);

      // coefficient load, both lanes
      for (int k = 0; k < 64; k++)
         step(0, 0, 0, 0, 0, 1, int'($urandom_range(0, 4000)) - 2000,
              1, int'($urandom_range(0, 4000)) - 2000, k);

      // R1 R2: independent lanes with gaps
      tag = "R1 R2";
      cfg_mode_p = 2'b00; cfg_mode_s = 2'b00; cfg_en_p = 1; cfg_en_s = 1;
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, 32767, 0, 0, 0, 0, 0, 0, 0);
      idle(5);
      for (int i = 0; i < 300; i++)
         step(0, ($urandom_range(0, 3) != 0), rnd16(), ($urandom_range(0, 1) != 0), rnd16(),
              0, 0, 0, 0, 0);

      // R7: mode pins moved without clear
      tag = "R7";
      cfg_mode_p = 2'b10; cfg_mode_s = 2'b01; cfg_en_s = 0;
      for (int i = 0; i < 60; i++)
         step(0, ($urandom_range(0, 2) != 0), rnd16(), ($urandom_range(0, 1) != 0), rnd16(),
              0, 0, 0, 0, 0);

      // R4 R5 R6: joined 128-tap filter, secondary input driven but ignored
      tag = "R4 R5 R6";
      step(1, 1, rnd16(), 1, rnd16(), 0, 0, 0, 0, 0);
      for (int i = 0; i < 400; i++)
         step(0, ($urandom_range(0, 4) != 0), rnd16(), ($urandom_range(0, 1) != 0), rnd16(),
              0, 0, 0, 0, 0);

      // R8: clear mid-stream keeps coefficients, flushes pipeline
      tag = "R8";
      step(0, 1, rnd16(), 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, rnd16(), 0, 0, 0, 0, 0, 0, 0);
      step(1, 1, rnd16(), 1, rnd16(), 0, 0, 0, 0, 0);
      for (int i = 0; i < 150; i++)
         step(0, ($urandom_range(0, 3) != 0), rnd16(), ($urandom_range(0, 1) != 0), rnd16(),
              0, 0, 0, 0, 0);

      // R3: rounding and saturation on the primary alone
      tag = "R3";
      cfg_mode_p = 2'b00; cfg_mode_s = 2'b00; cfg_en_p = 1; cfg_en_s = 1;
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 64; k++) step(0, 0, 0, 0, 0, 1, (k == 0) ? 1 : 0, 0, 0, k);
      step(0, 1, 16384, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, 16383, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, -16384, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, -16385, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 16384, 0, 0, 0);
      step(0, 1, 3, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, -3, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 64; k++) step(0, 0, 0, 0, 0, 1, 32767, 0, 0, k);
      for (int i = 0; i < 12; i++) step(0, 1, 32767, 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 80; i++) step(0, 1, -32768, 0, 0, 0, 0, 0, 0, 0);
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule